// File: doc/BRIEF.md
# UART Interrupt and Receive-Timeout Controller

This block turns FIFO occupancy, line events and a receive-idle timer into a single interrupt request and a DMA-busy flag for one UART channel. It keeps a four-bit source-pending register, a mask and the masked pending value. Software clears source bits by writing ones to them. The transmit and receive thresholds come from 3-bit trigger fields. Each field is scaled by a multiplier that depends on the channel number, so several channels with different FIFO depths share the same logic.

The receive timer counts baud ticks. When timeouts are enabled, each received byte re-arms it. It expires after a programmable number of frame times, and a frame time is a given number of bit periods. On expiry, if data is waiting or the force-on-empty control is set, the block raises the receive source and a sticky timeout flag. Software clears that flag with a write-one. The serial datapath, the FIFOs and the bus decoding sit outside this block. Every output is registered and reflects the inputs one clock edge earlier.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the source-pending, mask and pending registers, the timeout flag, `irq` and `dma_busy`.
- R2: `pend` equals `src_pend` AND NOT `mask`. `irq` is high exactly when `pend` is non-zero. A mask write loads `wr_data` into `mask`. All of these take effect at the next clock edge.
- R3: A write with `wr_pend` or with `wr_src` clears the `src_pend` bits (and so the `pend` bits) selected by ones in `wr_data`. A source whose set condition is true in the same cycle stays set.
- R4: The trigger multiplier is 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for channels 5 to 7.
- R5: The receive level is (receive field + 1) × multiplier. The transmit level is the transmit field × multiplier.
- R6: The transmit source (bit 2) is set when `fifo_en` is high and `tx_count` ≤ transmit level.
- R7: The receive source (bit 0) is set in two cases. With `fifo_en` high, it is set when `rx_count` ≥ receive level, or when `rx_count` ≠ 0 and `rxto_en` is low. With `fifo_en` low, it is set when `rx_ready` is high.
- R8: An `err_evt` pulse sets the error source (bit 1). A `modem_evt` pulse sets the modem source (bit 3).
- R9: With `rxto_en` high and `rxto_mult` ≠ 0, a `rx_push` pulse restarts the timer. After `rxto_mult` × `frame_bits` `baud_tick` cycles it expires. If `rx_ready` or `rxto_force` is high at expiry, `rx_timeout` and source bit 0 are set on the second clock edge after the final tick.
- R10: The timer is cancelled when the FIFO-mode receive condition of R7 holds. It stays idle while `rxto_mult` is zero or `rxto_en` is low. A cancelled or idle timer never raises `rx_timeout`.
- R11: A `wr_tstat` write with `wr_data[3]` = 1 clears `rx_timeout`. With `wr_data[3]` = 0 the flag is left unchanged.
- R12: `dma_busy` is high when `rx_mode` = 2'b10 and `rx_count` = 0, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan | input | 3 | Channel number selecting the trigger multiplier |
| fifo_en | input | 1 | FIFO mode enable |
| rx_fld | input | 3 | Receive trigger field |
| tx_fld | input | 3 | Transmit trigger field |
| rx_count | input | 9 | Receive FIFO occupancy |
| tx_count | input | 9 | Transmit FIFO occupancy |
| rx_ready | input | 1 | Receive data available |
| rx_mode | input | 2 | Receive transfer mode (2'b10 = DMA) |
| rxto_en | input | 1 | Receive timeout enable |
| rxto_force | input | 1 | Let the timeout fire with no data waiting |
| rxto_mult | input | 4 | Timeout length in frame times |
| frame_bits | input | 4 | Bit periods per frame |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| rx_push | input | 1 | Pulse per received byte |
| err_evt | input | 1 | Error event pulse |
| modem_evt | input | 1 | Modem event pulse |
| wr_pend | input | 1 | Write-one-to-clear on pending |
| wr_src | input | 1 | Write-one-to-clear on source-pending |
| wr_mask | input | 1 | Mask write strobe |
| wr_tstat | input | 1 | Timeout status write strobe |
| wr_data | input | 4 | Write data |
| src_pend | output | 4 | Source-pending register |
| pend | output | 4 | Masked pending register |
| mask | output | 4 | Mask register |
| rx_timeout | output | 1 | Sticky receive timeout flag |
| irq | output | 1 | Interrupt request |
| dma_busy | output | 1 | Receive DMA busy |

## Verification
A wrong multiplier or an off-by-one in a level compare shows at `src_pend` on the first edge after the count reaches the boundary. The bench therefore sweeps every channel and field at the exact level and one step past it. A timer that counts wrong fires early or late, and the error shows in the cycle where `rx_timeout` rises compared with the tick count the bench computes. A lost cancel or a lost restart shows as a flag that rises when none is expected. A mask or clear defect shows at `pend` and `irq` one edge after the write.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC    = 4;
  localparam int SRC_RX  = 0;
  localparam int SRC_ERR = 1;
  localparam int SRC_TX  = 2;
  localparam int SRC_MDM = 3;
  localparam int TO_BIT  = 3;
  localparam int TRIG_W  = 3;
  localparam int LVL_W   = 9;
endpackage

// File: rtl/uart_trig_scale.sv
module uart_trig_scale #(
  parameter int CH_W     = 3,
  parameter int FLD_W    = 3,
  parameter int LVL_W    = 9,
  parameter bit PLUS_ONE = 1'b0
) (
  input  logic [CH_W-1:0]  chan,
  input  logic [FLD_W-1:0] fld,
  output logic [LVL_W-1:0] lvl
);
  logic [LVL_W-1:0] steps;

  generate
    if (PLUS_ONE) begin : g_rx
      assign steps = LVL_W'(fld) + LVL_W'(1);
    end else begin : g_tx
      assign steps = LVL_W'(fld);
    end
  endgenerate

  always_comb begin
    case (int'(chan))
      0:       lvl = steps << 5;
      1, 4:    lvl = steps << 3;
      2, 3:    lvl = steps << 1;
      default: lvl = '0;
    endcase
  end

  always_comb begin
    if (int'(chan) > 4) assert_nochan_R4: assert (lvl == '0);
  end
endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer #(
  parameter int FRM_W = 4,
  parameter int MUL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [MUL_W-1:0] mult,
  input  logic [FRM_W-1:0] frame_bits,
  input  logic             push,
  input  logic             cancel,
  input  logic             tick,
  output logic             expire
);
  logic             armed_q;
  logic             exp_q;
  logic [FRM_W-1:0] bit_q;
  logic [MUL_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      exp_q   <= 1'b0;
      bit_q   <= '0;
      word_q  <= '0;
    end else begin
      exp_q <= 1'b0;
      if (cancel || !enable || mult == '0) begin
        armed_q <= 1'b0;
        bit_q   <= '0;
        word_q  <= '0;
      end else if (push) begin
        armed_q <= 1'b1;
        bit_q   <= '0;
        word_q  <= '0;
      end else if (armed_q && tick) begin
        if (bit_q == frame_bits - FRM_W'(1)) begin
          bit_q <= '0;
          if (word_q == mult - MUL_W'(1)) begin
            word_q  <= '0;
            armed_q <= 1'b0;
            exp_q   <= 1'b1;
          end else begin
            word_q <= word_q + MUL_W'(1);
          end
        end else begin
          bit_q <= bit_q + FRM_W'(1);
        end
      end
    end
  end

  assign expire = exp_q;

  assert_expire_armed_R9: assert property (@(posedge clk) disable iff (rst)
    exp_q |-> $past(armed_q));
  assert_hold_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (mult == '0) |=> !armed_q);
endmodule

// File: rtl/uart_int_regs.sv
module uart_int_regs
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wd,
  input  logic            fire,
  input  logic            tstat_clr,
  output logic [NSRC-1:0] src_q,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] mask_q,
  output logic            flag_q,
  output logic            irq_q
);
  logic [NSRC-1:0] src_d, mask_d, pend_d;

  always_comb begin
    src_d  = (src_q & ~clr_vec) | set_vec;
    mask_d = mask_we ? mask_wd : mask_q;
    pend_d = src_d & ~mask_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      mask_q <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      mask_q <= mask_d;
      pend_q <= pend_d;
      irq_q  <= |pend_d;
      if (fire)           flag_q <= 1'b1;
      else if (tstat_clr) flag_q <= 1'b0;
    end
  end

  assert_pend_mirror_R2: assert property (@(posedge clk) disable iff (rst)
    pend_q == (src_q & ~mask_q));
  assert_irq_level_R2: assert property (@(posedge clk) disable iff (rst)
    irq_q == (pend_q != '0));
  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_vec != '0) |=> ((src_q & $past(clr_vec & ~set_vec)) == '0));
  assert_flag_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(fire));
  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (tstat_clr && !fire) |=> !flag_q);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int CNT_W = 9,
  parameter int FRM_W = 4,
  parameter int MUL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CH_W-1:0]  chan,
  input  logic             fifo_en,
  input  logic [2:0]       rx_fld,
  input  logic [2:0]       tx_fld,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             rx_ready,
  input  logic [1:0]       rx_mode,
  input  logic             rxto_en,
  input  logic             rxto_force,
  input  logic [MUL_W-1:0] rxto_mult,
  input  logic [FRM_W-1:0] frame_bits,
  input  logic             baud_tick,
  input  logic             rx_push,
  input  logic             err_evt,
  input  logic             modem_evt,
  input  logic             wr_pend,
  input  logic             wr_src,
  input  logic             wr_mask,
  input  logic             wr_tstat,
  input  logic [3:0]       wr_data,
  output logic [3:0]       src_pend,
  output logic [3:0]       pend,
  output logic [3:0]       mask,
  output logic             rx_timeout,
  output logic             irq,
  output logic             dma_busy
);
  localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

  logic [LVL_W-1:0] rx_lvl, tx_lvl;
  logic [CMP_W-1:0] rx_cnt_x, tx_cnt_x, rx_lvl_x, tx_lvl_x;
  logic             rx_fifo_set, rx_set, tx_set, expire, fire;
  logic [NSRC-1:0]  set_vec, clr_vec;
  logic             dma_q;

  uart_trig_scale #(.CH_W(CH_W), .FLD_W(TRIG_W), .LVL_W(LVL_W), .PLUS_ONE(1'b1))
    u_rx_lvl (.chan(chan), .fld(rx_fld), .lvl(rx_lvl));
  uart_trig_scale #(.CH_W(CH_W), .FLD_W(TRIG_W), .LVL_W(LVL_W), .PLUS_ONE(1'b0))
    u_tx_lvl (.chan(chan), .fld(tx_fld), .lvl(tx_lvl));

  always_comb begin
    rx_cnt_x    = CMP_W'(rx_count);
    tx_cnt_x    = CMP_W'(tx_count);
    rx_lvl_x    = CMP_W'(rx_lvl);
    tx_lvl_x    = CMP_W'(tx_lvl);
    rx_fifo_set = fifo_en && ((rx_cnt_x >= rx_lvl_x) ||
                              (rx_count != '0 && !rxto_en));
    tx_set      = fifo_en && (tx_cnt_x <= tx_lvl_x);
    fire        = expire && (rx_ready || rxto_force);
    rx_set      = (fifo_en ? rx_fifo_set : rx_ready) || fire;
    set_vec          = '0;
    set_vec[SRC_RX]  = rx_set;
    set_vec[SRC_ERR] = err_evt;
    set_vec[SRC_TX]  = tx_set;
    set_vec[SRC_MDM] = modem_evt;
    clr_vec = (wr_pend || wr_src) ? wr_data : '0;
  end

  uart_rx_timer #(.FRM_W(FRM_W), .MUL_W(MUL_W)) u_timer (
    .clk(clk), .rst(rst), .enable(rxto_en), .mult(rxto_mult),
    .frame_bits(frame_bits), .push(rx_push), .cancel(rx_fifo_set),
    .tick(baud_tick), .expire(expire)
  );

  uart_int_regs u_regs (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .mask_we(wr_mask), .mask_wd(wr_data), .fire(fire),
    .tstat_clr(wr_tstat && wr_data[TO_BIT]),
    .src_q(src_pend), .pend_q(pend), .mask_q(mask),
    .flag_q(rx_timeout), .irq_q(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) dma_q <= 1'b0;
    else     dma_q <= (rx_mode == 2'b10) && (rx_count == '0);
  end
  assign dma_busy = dma_q;

  assert_dma_R12: assert property (@(posedge clk) disable iff (rst)
    dma_q |-> $past(rx_mode == 2'b10 && rx_count == '0));
endmodule

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] chan = '0;
  logic fifo_en = 0, rx_ready = 0, rxto_en = 0, rxto_force = 0;
  logic [2:0] rx_fld = '0, tx_fld = '0;
  logic [8:0] rx_count = '0, tx_count = '0;
  logic [1:0] rx_mode = '0;
  logic [3:0] rxto_mult = '0, frame_bits = 4'd10;
  logic baud_tick = 0, rx_push = 0, err_evt = 0, modem_evt = 0;
  logic wr_pend = 0, wr_src = 0, wr_mask = 0, wr_tstat = 0;
  logic [3:0] wr_data = '0;
  logic [3:0] src_pend, pend, mask;
  logic rx_timeout, irq, dma_busy;
  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  uart_irq_ctrl u0 (.*);

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int bmult(int ch);
    if (ch == 0) return 32;
    if (ch == 1 || ch == 4) return 8;
    if (ch == 2 || ch == 3) return 2;
    return 0;
  endfunction

  task automatic clr_all();
    wr_src = 1; wr_data = 4'hF; step(); wr_src = 0;
    wr_tstat = 1; step(); wr_tstat = 0; wr_data = 0;
  endtask

  task automatic ticks(int n);
    baud_tick = 1; step(n); baud_tick = 0;
  endtask

  task automatic push();
    rx_push = 1; step(); rx_push = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 0;
    step();
    check("R1 src", src_pend, 0); check("R1 mask", mask, 0);
    check("R1 irq", irq, 0); check("R1 dma", dma_busy, 0);
    check("R1 flag", rx_timeout, 0);

    // R4/R5/R6/R7 sweep: clearing every cycle, src shows set conditions
    fifo_en = 1; rxto_en = 1; wr_src = 1; wr_data = 4'hF;
    for (int ch = 0; ch < 8; ch++) begin
      for (int f = 0; f < 8; f++) begin
        int m, tl, rl;
        m = bmult(ch); tl = f * m; rl = (f + 1) * m;
        chan = 3'(ch); tx_fld = 3'(f); rx_fld = 3'(f);
        tx_count = 9'(tl); rx_count = 9'(rl);
        step();
        check("R6 tx at level (R4 R5)", src_pend[2], 1);
        check("R7 rx at level (R4 R5)", src_pend[0], 1);
        tx_count = 9'(tl + 1); rx_count = (rl == 0) ? 9'd0 : 9'(rl - 1);
        step();
        check("R6 tx above level (R4 R5)", src_pend[2], 0);
        check("R7 rx below level (R4 R5)", src_pend[0], (rl == 0) ? 1 : 0);
      end
    end
    // R7 data present, timeout disabled; non-FIFO mode
    chan = 0; rx_fld = 7; tx_count = 9'd300; rx_count = 1; rxto_en = 0;
    step(); check("R7 data no timeout", src_pend[0], 1);
    rxto_en = 1; step(); check("R7 data with timeout", src_pend[0], 0);
    fifo_en = 0; rx_count = 0; tx_count = 0; rx_ready = 1;
    step(); check("R7 nonfifo ready", src_pend, 4'b0001);
    rx_ready = 0; step(); check("R6 nonfifo no tx", src_pend, 0);
    wr_src = 0; wr_data = 0;

    // R8 / R2 masking
    err_evt = 1; step(); err_evt = 0;
    check("R8 err", src_pend, 4'b0010); check("R2 pend", pend, 4'b0010);
    check("R2 irq", irq, 1);
    wr_mask = 1; wr_data = 4'b0010; step(); wr_mask = 0; wr_data = 0;
    check("R2 mask", mask, 4'b0010); check("R2 masked pend", pend, 0);
    check("R2 masked irq", irq, 0); check("R2 src kept", src_pend, 4'b0010);
    wr_mask = 1; wr_data = 0; step(); wr_mask = 0;
    check("R2 unmask irq", irq, 1);
    // R3 clears
    wr_pend = 1; wr_data = 4'b0010; step(); wr_pend = 0; wr_data = 0;
    check("R3 pend clear", src_pend, 0); check("R3 pend clear irq", irq, 0);
    modem_evt = 1; err_evt = 1; step(); modem_evt = 0; err_evt = 0;
    check("R8 modem+err", src_pend, 4'b1010);
    wr_src = 1; wr_data = 4'b1000; step(); wr_src = 0; wr_data = 0;
    check("R3 src clear", src_pend, 4'b0010); check("R3 pend follows", pend, 4'b0010);
    fifo_en = 1; tx_count = 0; rx_count = 1; rxto_en = 1;
    wr_src = 1; wr_data = 4'b0100; step(); wr_src = 0; wr_data = 0;
    check("R3 set wins", src_pend[2], 1);

    // R9 timeout
    tx_count = 9'd300; rx_ready = 1; rxto_mult = 3; frame_bits = 10;
    clr_all();
    push(); ticks(29);
    check("R9 early flag", rx_timeout, 0); check("R9 early src", src_pend[0], 0);
    ticks(1); check("R9 expiry edge", rx_timeout, 0);
    step(); check("R9 flag", rx_timeout, 1); check("R9 src", src_pend[0], 1);
    // R11
    wr_tstat = 1; wr_data = 4'b0111; step(); wr_tstat = 0;
    check("R11 zero write keeps", rx_timeout, 1);
    wr_tstat = 1; wr_data = 4'b1000; step(); wr_tstat = 0; wr_data = 0;
    check("R11 clear", rx_timeout, 0);
    // R10 restart
    clr_all(); push(); ticks(20); push(); ticks(29); step();
    check("R10 restart early", rx_timeout, 0);
    ticks(1); step(); check("R10 restart fire", rx_timeout, 1);
    // R10 cancel
    clr_all(); push(); ticks(10);
    rx_count = 9'd256; step(); rx_count = 1;
    ticks(40); step(); check("R10 cancel", rx_timeout, 0);
    // R10 mult zero
    rxto_mult = 0; push(); ticks(40); step();
    check("R10 mult zero", rx_timeout, 0);
    rxto_mult = 3;
    // R10 disabled
    rxto_en = 0; rx_count = 0; push(); ticks(40); step();
    check("R10 disabled", rx_timeout, 0);
    rxto_en = 1; rx_count = 1;
    // R9 force / no condition
    rx_ready = 0; rxto_force = 1; clr_all(); push(); ticks(30); step();
    check("R9 force fire", rx_timeout, 1);
    rxto_force = 0; clr_all(); push(); ticks(30); step();
    check("R9 no data no fire", rx_timeout, 0);
    check("R9 no data src", src_pend[0], 0);

    // R12 DMA busy
    rx_mode = 2'b10; rx_count = 0; step(); check("R12 busy", dma_busy, 1);
    rx_count = 1; step(); check("R12 data", dma_busy, 0);
    rx_mode = 2'b11; rx_count = 0; step(); check("R12 mode", dma_busy, 0);
    rx_mode = 2'b01; step(); check("R12 mode01", dma_busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule